// File: doc/BRIEF.md
# Multi-CPU Limit Timer Bank

This block holds a set of down-counting interval timers behind a small register bus: one private timer for each CPU and one shared master timer. Each timer is loaded with a limit value and counts down from it by one every clock. When it runs out it reloads itself and raises a sticky expiry flag. Software programs a period by writing the limit word. It acknowledges an expiry by reading the limit word, which returns the flag and clears it. A second, non-clearing view of the limit word lets software look at or retune a timer without losing a pending expiry.

Each private timer's flag drives that CPU's level-14 interrupt line and no other. The master timer's flag drives the level-10 interrupt line of every CPU at once. A single configuration word sits in the master timer's register group and reads zero after reset.

Bus address layout: the upper address bits select a timer (index 0..NCPU-1 are the private timers, index NCPU is the master timer), and the low three bits select the word inside the group. Word 0 is the clearing limit view, word 1 the current count, word 2 the non-clearing limit view, and word 4 the configuration (master group only).

Top module: `lmt_timer_bank`

## Requirements
- R1: After reset all interrupt outputs are low, and every limit word (private and master) reads 0x009C4000 with the flag clear.
- R2: Every timer data word carries the expiry flag in bit 31 and the 21-bit count or limit value in bits 30:10. Bits 9:0 always read zero, and a write to a limit word stores only bits 30:10.
- R3: After a limit write of value L, the count word reads L, and it drops by one on each following clock. The count never exceeds the limit.
- R4: A timer whose count is 1 or 0 reloads the limit value on the next clock and sets its flag, so a limit L of at least 1 gives an expiry every L clocks after the write.
- R5: A read of word 0 returns the flag and limit and clears the flag at that same clock edge. If the timer expires at that edge, the flag stays set.
- R6: A read of word 2 returns the same data as word 0 but leaves the flag unchanged. A write to word 2 loads the limit and count with the new value and keeps the flag.
- R7: A write to word 0 loads the limit and count with the new value and clears the flag.
- R8: The flag of private timer i drives irq_lvl14[i] only. The master timer's flag drives every bit of irq_lvl10, and no private timer affects irq_lvl10.
- R9: The configuration word (master group, word 4) reads zero after reset. It stores the low NCPU bits of a write and reads the upper bits as zero.
- R10: Read data and bus_rvalid appear one clock after a read request. bus_rvalid is low otherwise, and reads of unmapped words or timer indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access request for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | $clog2(NCPU+1)+3 | Timer index in upper bits, word select in bits 2:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after a read request |
| irq_lvl14 | output | NCPU | Per-CPU level-14 interrupt from the private timers |
| irq_lvl10 | output | NCPU | Per-CPU level-10 interrupt from the master timer |

## Verification
The hardest cases to reach from the ports are those that need a flag already set while another access hits the same timer: the non-clearing read, the flag-keeping retune and the clearing write. The stimulus programs short limits and counts clocks after each write, so the expiry lands on a known cycle. Each access is then issued while the flag is known to be high. Routing is tested by first parking every timer on a very long limit, so that only the timer under test can raise a line.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FLAG_BIT  = 31;
  localparam int unsigned FIELD_LSB = 10;
  localparam int unsigned FIELD_W   = FLAG_BIT - FIELD_LSB;
  localparam int unsigned WSEL_W    = 3;

  typedef enum logic [WSEL_W-1:0] {
    W_LIMIT = 3'd0,
    W_COUNT = 3'd1,
    W_LIMNC = 3'd2,
    W_CFG   = 3'd4
  } word_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic flag,
                                                  input logic [FIELD_W-1:0] val);
    return {flag, val, {FIELD_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/lmt_timer_core.sv
module lmt_timer_core
  import lmt_pkg::*;
#(
  parameter int unsigned        CW      = FIELD_W,
  parameter logic [CW-1:0]      RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_clr,
  input  logic          ld_keep,
  input  logic [CW-1:0] ld_val,
  input  logic          rd_clr,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lim_o,
  output logic          flag_o
);
  logic [CW-1:0] lim_q, lim_d, cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          lim_en, expire;

  assign lim_en = ld_clr | ld_keep;
  assign expire = (cnt_q <= CW'(1));

  always_comb begin
    lim_d  = ld_val;
    cnt_d  = cnt_q - CW'(1);
    flag_d = flag_q & ~rd_clr;
    if (lim_en) begin
      cnt_d  = ld_val;
      flag_d = ld_keep ? flag_q : 1'b0;
    end else if (expire) begin
      cnt_d  = lim_q;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= RST_VAL;
      cnt_q  <= RST_VAL;
      flag_q <= 1'b0;
    end else begin
      if (lim_en) lim_q <= lim_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/lmt_decode.sv
module lmt_decode
  import lmt_pkg::*;
#(
  parameter int unsigned NT    = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic                    req,
  input  logic                    wr,
  input  logic [IDX_W+WSEL_W-1:0] addr,
  output logic [NT-1:0]           wr_lim,
  output logic [NT-1:0]           wr_nc,
  output logic [NT-1:0]           rd_clr,
  output logic                    cfg_wr,
  output logic [IDX_W-1:0]        idx,
  output logic [WSEL_W-1:0]       wsel,
  output logic                    idx_ok
);
  assign idx    = addr[IDX_W+WSEL_W-1:WSEL_W];
  assign wsel   = addr[WSEL_W-1:0];
  assign idx_ok = (int'(idx) < NT);

  always_comb begin
    wr_lim = '0;
    wr_nc  = '0;
    rd_clr = '0;
    cfg_wr = 1'b0;
    if (req && idx_ok) begin
      unique case (wsel)
        W_LIMIT: begin
          if (wr) wr_lim[idx] = 1'b1;
          else    rd_clr[idx] = 1'b1;
        end
        W_LIMNC: if (wr) wr_nc[idx] = 1'b1;
        W_CFG:   if (wr && (int'(idx) == NT - 1)) cfg_wr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lmt_rdmux.sv
module lmt_rdmux
  import lmt_pkg::*;
#(
  parameter int unsigned NT    = 5,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CFG_W = 4
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [WSEL_W-1:0]        wsel,
  input  logic                     idx_ok,
  input  logic [NT-1:0][FIELD_W-1:0] cnt_a,
  input  logic [NT-1:0][FIELD_W-1:0] lim_a,
  input  logic [NT-1:0]            flg,
  input  logic [CFG_W-1:0]         cfg,
  output logic [WORD_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    if (idx_ok) begin
      unique case (wsel)
        W_LIMIT, W_LIMNC: rdata = pack_word(flg[idx], lim_a[idx]);
        W_COUNT:          rdata = pack_word(flg[idx], cnt_a[idx]);
        W_CFG:            if (int'(idx) == NT - 1) rdata = WORD_W'(cfg);
        default:          rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lmt_timer_bank.sv
module lmt_timer_bank
  import lmt_pkg::*;
#(
  parameter int unsigned       NCPU    = 4,
  parameter logic [WORD_W-1:0] LIM_RST = 32'h009C_4000,
  localparam int unsigned      NT      = NCPU + 1,
  localparam int unsigned      IDX_W   = $clog2(NT),
  localparam int unsigned      AW      = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [NCPU-1:0]   irq_lvl14,
  output logic [NCPU-1:0]   irq_lvl10
);
  localparam logic [FIELD_W-1:0] RST_FIELD = LIM_RST[FLAG_BIT-1:FIELD_LSB];

  logic [1:0]                  rst_sync;
  logic                        rst_sync_n;
  logic [NT-1:0]               wr_lim_v, wr_nc_v, rd_clr_v, flg_v;
  logic [NT-1:0][FIELD_W-1:0]  cnt_a, lim_a;
  logic                        cfg_wr, idx_ok, rd_req;
  logic [IDX_W-1:0]            idx;
  logic [WSEL_W-1:0]           wsel;
  logic [FIELD_W-1:0]          wval;
  logic [NCPU-1:0]             cfg_q, cfg_d;
  logic [WORD_W-1:0]           rdata_q, rdata_d;
  logic                        rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign wval   = bus_wdata[FLAG_BIT-1:FIELD_LSB];
  assign rd_req = bus_req & ~bus_wr;

  lmt_decode #(.NT(NT), .IDX_W(IDX_W)) i_decode (
    .req    (bus_req),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wr_lim (wr_lim_v),
    .wr_nc  (wr_nc_v),
    .rd_clr (rd_clr_v),
    .cfg_wr (cfg_wr),
    .idx    (idx),
    .wsel   (wsel),
    .idx_ok (idx_ok)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    lmt_timer_core #(.CW(FIELD_W), .RST_VAL(RST_FIELD)) i_core (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .ld_clr  (wr_lim_v[t]),
      .ld_keep (wr_nc_v[t]),
      .ld_val  (wval),
      .rd_clr  (rd_clr_v[t]),
      .cnt_o   (cnt_a[t]),
      .lim_o   (lim_a[t]),
      .flag_o  (flg_v[t])
    );
  end

  lmt_rdmux #(.NT(NT), .IDX_W(IDX_W), .CFG_W(NCPU)) i_rdmux (
    .idx    (idx),
    .wsel   (wsel),
    .idx_ok (idx_ok),
    .cnt_a  (cnt_a),
    .lim_a  (lim_a),
    .flg    (flg_v),
    .cfg    (cfg_q),
    .rdata  (rdata_d)
  );

  assign cfg_d = bus_wdata[NCPU-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q   <= cfg_d;
      if (rd_req) rdata_q <= rdata_d;
      rvalid_q <= rd_req;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_lvl14  = flg_v[NCPU-1:0];
  assign irq_lvl10  = {NCPU{flg_v[NT-1]}};
endmodule

// File: rtl/lmt_timer_bank_chk.sv
module lmt_timer_bank_chk
  import lmt_pkg::*;
#(
  parameter int unsigned NCPU = 4,
  localparam int unsigned NT  = NCPU + 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_req,
  input logic                       bus_wr,
  input logic                       bus_rvalid,
  input logic [NCPU-1:0]            irq_lvl10,
  input logic [NT-1:0]              flg_v,
  input logic [NT-1:0]              wr_lim_v,
  input logic [NT-1:0]              wr_nc_v,
  input logic [NT-1:0]              rd_clr_v,
  input logic [NT-1:0][FIELD_W-1:0] cnt_a,
  input logic [NT-1:0][FIELD_W-1:0] lim_a,
  input logic [FIELD_W-1:0]         wval
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    p_count_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_a[t] <= lim_a[t]);

    p_expiry_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_a[t] <= FIELD_W'(1) && !wr_lim_v[t] && !wr_nc_v[t])
      |=> (flg_v[t] && cnt_a[t] == $past(lim_a[t])));

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_v[t] && cnt_a[t] > FIELD_W'(1)) |=> !flg_v[t]);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_v[t] && !rd_clr_v[t] && !wr_lim_v[t]) |=> flg_v[t]);

    p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lim_v[t] |=> (!flg_v[t] && cnt_a[t] == $past(wval)));
  end

  p_master_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lvl10[0]) |-> ($past(cnt_a[NT-1]) <= FIELD_W'(1)));

  p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid);

  p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_wr) |=> !bus_rvalid);
endmodule

bind lmt_timer_bank lmt_timer_bank_chk #(.NCPU(NCPU)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_req    (bus_req),
  .bus_wr     (bus_wr),
  .bus_rvalid (bus_rvalid),
  .irq_lvl10  (irq_lvl10),
  .flg_v      (flg_v),
  .wr_lim_v   (wr_lim_v),
  .wr_nc_v    (wr_nc_v),
  .rd_clr_v   (rd_clr_v),
  .cnt_a      (cnt_a),
  .lim_a      (lim_a),
  .wval       (wval)
);

// File: tb/test_lmt_timer_bank.sv
module test_lmt_timer_bank;
  localparam int unsigned NCPU  = 4;
  localparam int unsigned NT    = NCPU + 1;
  localparam int unsigned IDX_W = $clog2(NT);
  localparam int unsigned AW    = IDX_W + 3;
  localparam int unsigned MST   = NCPU;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_req, bus_wr;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_rvalid;
  logic [NCPU-1:0]   irq_lvl14, irq_lvl10;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lmt_timer_bank #(.NCPU(NCPU)) i_lmt_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_lvl14(irq_lvl14), .irq_lvl10(irq_lvl10)
  );

  function automatic logic [31:0] fw(input logic flag, input int unsigned v);
    return {flag, v[20:0], 10'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int unsigned idx, input int unsigned w,
                           input logic [31:0] d);
    bus_req   = 1'b1;
    bus_wr    = 1'b1;
    bus_addr  = {idx[IDX_W-1:0], w[2:0]};
    bus_wdata = d;
    @(negedge clk);
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input int unsigned idx, input int unsigned w,
                          output logic [31:0] d);
    bus_req  = 1'b1;
    bus_wr   = 1'b0;
    bus_addr = {idx[IDX_W-1:0], w[2:0]};
    @(negedge clk);
    bus_req  = 1'b0;
    check(bus_rvalid === 1'b1, "R10 rvalid after read", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic wait_irq14(input int unsigned cpu, input int unsigned lim);
    for (int k = 0; k < lim && irq_lvl14[cpu] !== 1'b1; k++) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    logic [31:0] d;
    check(irq_lvl14 === '0 && irq_lvl10 === '0, "R1 irqs low after reset",
          32'({irq_lvl14, irq_lvl10}), 32'd0);
    bus_read(0, 0, d);
    check(d === 32'h009C_4000, "R1 private limit reset", d, 32'h009C_4000);
    bus_read(MST, 0, d);
    check(d === 32'h009C_4000, "R1 master limit reset", d, 32'h009C_4000);
  endtask

  task automatic t_format_r2();
    logic [31:0] d;
    bus_write(0, 0, 32'hFFFF_FFFF);
    bus_read(0, 0, d);
    check(d === 32'h7FFF_FC00, "R2 field bits only", d, 32'h7FFF_FC00);
  endtask

  task automatic t_countdown_r3();
    logic [31:0] d;
    bus_write(0, 0, fw(0, 100));
    bus_read(0, 1, d);
    check(d === fw(0, 100), "R3 count starts at limit", d, fw(0, 100));
    bus_read(0, 1, d);
    check(d === fw(0, 99), "R3 count decrements", d, fw(0, 99));
  endtask

  task automatic t_expiry_r4();
    bus_write(0, 0, fw(0, 20));
    repeat (19) @(negedge clk);
    check(irq_lvl14[0] === 1'b0, "R4 no flag before period", 32'(irq_lvl14), 32'd0);
    @(negedge clk);
    check(irq_lvl14[0] === 1'b1, "R4 flag at period", 32'(irq_lvl14), 32'd1);
  endtask

  task automatic t_readclr_r5();
    logic [31:0] d;
    bus_read(0, 0, d);
    check(d === fw(1, 20), "R5 read returns flag", d, fw(1, 20));
    check(irq_lvl14[0] === 1'b0, "R5 read clears flag", 32'(irq_lvl14), 32'd0);
    bus_read(0, 0, d);
    check(d === fw(0, 20), "R5 flag gone on reread", d, fw(0, 20));
  endtask

  task automatic t_noclr_r6();
    logic [31:0] d;
    wait_irq14(0, 40);
    bus_read(0, 2, d);
    check(d === fw(1, 20), "R6 alias read data", d, fw(1, 20));
    check(irq_lvl14[0] === 1'b1, "R6 alias read keeps flag", 32'(irq_lvl14), 32'd1);
    bus_write(0, 2, fw(0, 30));
    check(irq_lvl14[0] === 1'b1, "R6 alias write keeps flag", 32'(irq_lvl14), 32'd1);
    bus_read(0, 1, d);
    check(d === fw(1, 30), "R6 alias write reloads count", d, fw(1, 30));
  endtask

  task automatic t_wrclr_r7();
    logic [31:0] d;
    wait_irq14(0, 40);
    check(irq_lvl14[0] === 1'b1, "R7 flag set before write", 32'(irq_lvl14), 32'd1);
    bus_write(0, 0, fw(0, 50));
    check(irq_lvl14[0] === 1'b0, "R7 write clears flag", 32'(irq_lvl14), 32'd0);
    bus_read(0, 1, d);
    check(d === fw(0, 50), "R7 write reloads count", d, fw(0, 50));
  endtask

  task automatic t_routing_r8();
    for (int t = 0; t < NT; t++) bus_write(t, 0, fw(0, 32'h10_0000));
    bus_write(1, 0, fw(0, 10));
    repeat (9) @(negedge clk);
    check(irq_lvl14 === '0 && irq_lvl10 === '0, "R8 quiet before expiry",
          32'({irq_lvl14, irq_lvl10}), 32'd0);
    @(negedge clk);
    check(irq_lvl14 === 4'b0010, "R8 private routed to own cpu", 32'(irq_lvl14), 32'h2);
    check(irq_lvl10 === 4'b0000, "R8 private not on level 10", 32'(irq_lvl10), 32'h0);
    bus_write(MST, 0, fw(0, 10));
    repeat (10) @(negedge clk);
    check(irq_lvl10 === 4'b1111, "R8 master on all cpus", 32'(irq_lvl10), 32'hF);
    check(irq_lvl14 === 4'b0010, "R8 master not on level 14", 32'(irq_lvl14), 32'h2);
  endtask

  task automatic t_cfg_r9();
    logic [31:0] d;
    bus_read(MST, 4, d);
    check(d === 32'h0, "R9 config zero after reset", d, 32'h0);
    bus_write(MST, 4, 32'hFFFF_FFFF);
    bus_read(MST, 4, d);
    check(d === 32'hF, "R9 config low bits only", d, 32'hF);
    bus_write(MST, 4, 32'h5);
    bus_read(MST, 4, d);
    check(d === 32'h5, "R9 config stores value", d, 32'h5);
  endtask

  task automatic t_bus_r10();
    logic [31:0] d;
    bus_read(0, 3, d);
    check(d === 32'h0, "R10 unmapped word reads zero", d, 32'h0);
    bus_read(6, 0, d);
    check(d === 32'h0, "R10 unmapped index reads zero", d, 32'h0);
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R10 rvalid low when idle", 32'(bus_rvalid), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_cfg_r9();
    t_format_r2();
    t_countdown_r3();
    t_expiry_r4();
    t_readclr_r5();
    t_noclr_r6();
    t_wrclr_r7();
    t_routing_r8();
    t_bus_r10();
    finish_run();
  end
endmodule